// File: doc/BRIEF.md
# Frame Capture Sequencing Controller

This block is the control state machine of a camera capture path that fills a queue of frame buffers. It reacts to single-cycle events: a buffer was queued, a buffer was dequeued, the camera interface reported end of frame, a DMA channel reported its end, an overrun was flagged. It also watches a level that says the DMA engine has halted. From these it drives an enable for the camera interface and a one-cycle start command for the DMA channels.

The controller never starts the DMA on the same frame that enabled the camera. It waits for an end-of-frame so that transfers begin on a frame boundary. A frame is resolved only once every DMA channel has reported its end. After each frame the controller does one of four things:
- it continues;
- it restarts the frame after an overrun;
- it recovers a lost hot-append, where buffers remain but the DMA has already halted;
- it stops once no buffers remain.

The list of queued buffers is modelled as an occupancy counter. Pixel data, descriptors and buffer memory lie outside the block.

Top module: `frame_capture_seq`

## Requirements
- R1: After reset `state_o` is STOP (code 2'b00), `cam_en_o` is 0 and `dma_start_o` is 0. A dequeue or an end-of-frame event in STOP leaves all outputs unchanged.
- R2: An enqueue in STOP moves the state to WAIT (code 2'b01) in the next cycle. In that cycle `cam_en_o` is 1 and `dma_start_o` stays 0.
- R3: An end-of-frame in WAIT produces a one-cycle `dma_start_o` pulse in the next cycle, and the state becomes RUN (code 2'b10).
- R4: In RUN, channel-end events are remembered per channel until the frame is resolved. The frame resolves only in the cycle where all NUM_CH channels (bit i of `ch_end_i` is channel i) have reported, in any order and over any number of cycles. Until then the state stays RUN with no pulse.
- R5: A frame that resolves with an overrun seen at any time during it behaves as follows. In the next cycle `ovr_restart_o` pulses, `cam_en_o` is 0 and the state is WAIT. The cycle after that, `cam_en_o` is 1 again. No buffer is released, and the next end-of-frame restarts the DMA.
- R6: A frame that resolves without overrun pulses `frame_done_o` in the next cycle and releases one buffer. If no buffer then remains, the state becomes STOP with `cam_en_o` 0.
- R7: If buffers remain after a clean frame and `dma_idle_i` is 1, the state becomes MISS (code 2'b11) with `cam_en_o` held at 1. The next end-of-frame pulses `dma_start_o` and returns the state to RUN.
- R8: If buffers remain after a clean frame and `dma_idle_i` is 0, the state stays RUN and no `dma_start_o` is issued.
- R9: Enqueue and dequeue events in WAIT, RUN or MISS never change the state. An enqueue in the same cycle as a frame release is counted, so the net buffer count is unchanged and capture does not stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_i | input | 1 | A buffer was queued (one-cycle event) |
| deq_i | input | 1 | A finished buffer was taken by software (one-cycle event) |
| eof_i | input | 1 | End of frame from the camera interface |
| ch_end_i | input | NUM_CH | Per-channel DMA end events |
| overrun_i | input | 1 | Overrun event for the current frame |
| dma_idle_i | input | 1 | DMA engine has halted (level) |
| cam_en_o | output | 1 | Camera interface enable |
| dma_start_o | output | 1 | One-cycle DMA start command |
| state_o | output | 2 | Capture state code |
| frame_done_o | output | 1 | One-cycle pulse: frame completed cleanly |
| ovr_restart_o | output | 1 | One-cycle pulse: frame restarted after overrun |

## Verification
The bound assertions check the following on every cycle:
- the camera stays disabled in STOP;
- an enqueue in STOP leads to WAIT with no DMA start;
- an end-of-frame in WAIT leads to a start pulse;
- an overrun restart comes with the camera off and the state WAIT;
- the two frame pulses are never active together;
- MISS always keeps the camera on.

Other behaviour depends on history and only the bench scenarios show it: channel ends spread over several cycles, the buffer count deciding between RUN, MISS and STOP, an enqueue merged with a release, and the camera re-enabling one cycle after an overrun.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   typedef enum logic [1:0] {
      ST_STOP = 2'b00,
      ST_WAIT = 2'b01,
      ST_RUN  = 2'b10,
      ST_MISS = 2'b11
   } cap_state_e;
endpackage

// File: rtl/fcs_chan_track.sv
module fcs_chan_track #(
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              clear_i,
   input  logic [NUM_CH-1:0] ch_end_i,
   input  logic              ovr_i,
   output logic              all_done_o,
   output logic              ovr_seen_o
);
   logic [NUM_CH-1:0] seen_q;
   logic              ovr_q;

   // sticky per-channel end flags
   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      seen_q[g] <= 1'b0;
         else if (clear_i)                seen_q[g] <= 1'b0;
         else if (arm_i && ch_end_i[g])   seen_q[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               ovr_q <= 1'b0;
      else if (clear_i)         ovr_q <= 1'b0;
      else if (arm_i && ovr_i)  ovr_q <= 1'b1;
   end

   assign all_done_o = arm_i && (&(seen_q | ch_end_i));
   assign ovr_seen_o = ovr_q || (arm_i && ovr_i);
endmodule

// File: rtl/fcs_buf_count.sv
module fcs_buf_count #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] count_o,
   output logic             next_empty_o
);
   localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             do_inc, do_dec;

   assign do_dec = dec_i && (cnt_q != '0);
   assign do_inc = inc_i && !(cnt_q == MAX_CNT && !do_dec);

   always_comb begin
      cnt_d = cnt_q;
      if (do_inc && !do_dec)      cnt_d = cnt_q + 1'b1;
      else if (do_dec && !do_inc) cnt_d = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count_o      = cnt_q;
   assign next_empty_o = (cnt_d == '0);
endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm
   import fcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enq_i,
   input  logic       eof_i,
   input  logic       frame_end_i,
   input  logic       ovr_seen_i,
   input  logic       next_empty_i,
   input  logic       dma_idle_i,
   output logic       release_o,
   output logic       clear_o,
   output logic       arm_o,
   output logic [1:0] state_o,
   output logic       cam_en_o,
   output logic       dma_start_o,
   output logic       frame_done_o,
   output logic       ovr_restart_o
);
   cap_state_e state_q, state_d;
   logic       start_ev, done_ev, ovr_ev;
   logic       cam_q, start_q, done_q, ovr_q;

   always_comb begin
      state_d  = state_q;
      start_ev = 1'b0;
      done_ev  = 1'b0;
      ovr_ev   = 1'b0;
      unique case (state_q)
         ST_STOP: if (enq_i) state_d = ST_WAIT;
         ST_WAIT, ST_MISS: if (eof_i) begin
            state_d  = ST_RUN;
            start_ev = 1'b1;
         end
         ST_RUN: if (frame_end_i) begin
            if (ovr_seen_i) begin
               ovr_ev  = 1'b1;
               state_d = ST_WAIT;
            end else begin
               done_ev = 1'b1;
               if (next_empty_i)    state_d = ST_STOP;
               else if (dma_idle_i) state_d = ST_MISS;
            end
         end
         default: state_d = ST_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_STOP;
         cam_q   <= 1'b0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cam_q   <= (state_d != ST_STOP) && !ovr_ev;
         start_q <= start_ev;
         done_q  <= done_ev;
         ovr_q   <= ovr_ev;
      end
   end

   assign release_o     = done_ev;
   assign clear_o       = frame_end_i || start_ev;
   assign arm_o         = (state_q == ST_RUN);
   assign state_o       = state_q;
   assign cam_en_o      = cam_q;
   assign dma_start_o   = start_q;
   assign frame_done_o  = done_q;
   assign ovr_restart_o = ovr_q;
endmodule

// File: rtl/frame_capture_seq.sv
module frame_capture_seq #(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_i,
   input  logic              deq_i,
   input  logic              eof_i,
   input  logic [NUM_CH-1:0] ch_end_i,
   input  logic              overrun_i,
   input  logic              dma_idle_i,
   output logic              cam_en_o,
   output logic              dma_start_o,
   output logic [1:0]        state_o,
   output logic              frame_done_o,
   output logic              ovr_restart_o
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("frame_capture_seq: NUM_CH must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("frame_capture_seq: CNT_W must be at least 1");
   end

   logic             arm, clear, frame_end, ovr_seen, release_buf, next_empty;
   logic [CNT_W-1:0] count;
   logic             deq_unused;

   // software dequeue takes finished buffers only; the active list is unaffected
   assign deq_unused = deq_i;

   fcs_chan_track #(.NUM_CH(NUM_CH)) u_track (
      .clk, .rst_n,
      .arm_i(arm), .clear_i(clear), .ch_end_i,
      .ovr_i(overrun_i),
      .all_done_o(frame_end), .ovr_seen_o(ovr_seen)
   );

   fcs_buf_count #(.CNT_W(CNT_W)) u_count (
      .clk, .rst_n,
      .inc_i(enq_i), .dec_i(release_buf),
      .count_o(count), .next_empty_o(next_empty)
   );

   fcs_fsm u_fsm (
      .clk, .rst_n,
      .enq_i, .eof_i,
      .frame_end_i(frame_end), .ovr_seen_i(ovr_seen),
      .next_empty_i(next_empty), .dma_idle_i,
      .release_o(release_buf), .clear_o(clear), .arm_o(arm),
      .state_o, .cam_en_o, .dma_start_o, .frame_done_o, .ovr_restart_o
   );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       enq_i,
   input logic       eof_i,
   input logic       cam_en_o,
   input logic       dma_start_o,
   input logic [1:0] state_o,
   input logic       frame_done_o,
   input logic       ovr_restart_o
);
   AST_STOP_CAM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00) |-> !cam_en_o && !dma_start_o); // R1

   AST_ENQ_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && enq_i) |=> (state_o == 2'b01 && cam_en_o && !dma_start_o)); // R2

   AST_EOF_STARTS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b01 && eof_i) |=> (dma_start_o && state_o == 2'b10)); // R3

   AST_OVR_STOPS_CAM: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_restart_o |-> (!cam_en_o && state_o == 2'b01)); // R5

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_done_o && ovr_restart_o)); // R6

   AST_MISS_CAM_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b11) |-> cam_en_o); // R7
endmodule

bind frame_capture_seq fcs_checker u_fcs_checker (
   .clk, .rst_n, .enq_i, .eof_i, .cam_en_o, .dma_start_o,
   .state_o, .frame_done_o, .ovr_restart_o
);

// File: tb/frame_capture_seq_bench.sv
module frame_capture_seq_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [1:0] st;
      logic       cam, dma, fd, ov;
      string      tag;
   } exp_t;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       enq_i = 0, deq_i = 0, eof_i = 0, overrun_i = 0, dma_idle_i = 0;
   logic [2:0] ch_end_i = '0;
   logic       cam_en_o, dma_start_o, frame_done_o, ovr_restart_o;
   logic [1:0] state_o;

   int   n_checks = 0, n_fail = 0;
   exp_t sb[$];
   bit   done_drv = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_capture_seq u_frame_capture_seq (
      .clk, .rst_n, .enq_i, .deq_i, .eof_i, .ch_end_i, .overrun_i, .dma_idle_i,
      .cam_en_o, .dma_start_o, .state_o, .frame_done_o, .ovr_restart_o
   );

   task automatic cmp(input exp_t e);
      n_checks++;
      if (state_o !== e.st || cam_en_o !== e.cam || dma_start_o !== e.dma ||
          frame_done_o !== e.fd || ovr_restart_o !== e.ov) begin
         n_fail++;
         $display("FAIL %s: got st=%b cam=%b dma=%b fd=%b ov=%b exp st=%b cam=%b dma=%b fd=%b ov=%b",
                  e.tag, state_o, cam_en_o, dma_start_o, frame_done_o, ovr_restart_o,
                  e.st, e.cam, e.dma, e.fd, e.ov);
      end
   endtask

   // driver: apply one cycle of events, push the outputs expected after the edge
   task automatic step(input logic e, d, f, input logic [2:0] ch, input logic ov, idle,
                       input logic [1:0] st, input logic cam, dma, fd, ovr, input string tag);
      exp_t x;
      @(negedge clk);
      enq_i = e; deq_i = d; eof_i = f; ch_end_i = ch; overrun_i = ov; dma_idle_i = idle;
      x.st = st; x.cam = cam; x.dma = dma; x.fd = fd; x.ov = ovr; x.tag = tag;
      sb.push_back(x);
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) cmp(sb.pop_front());
   end

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      r.st = 2'b00; r.cam = 0; r.dma = 0; r.fd = 0; r.ov = 0; r.tag = "R1 reset";
      cmp(r);
      //    enq deq eof ch     ov idle   st    cam dma fd ov
      step(0, 1, 0, 3'b000, 0, 0, 2'b00, 0, 0, 0, 0, "R1 deq in STOP");
      step(0, 0, 1, 3'b000, 0, 0, 2'b00, 0, 0, 0, 0, "R1 eof in STOP");
      step(1, 0, 0, 3'b000, 0, 0, 2'b01, 1, 0, 0, 0, "R2 enq starts camera");
      step(0, 0, 0, 3'b000, 0, 0, 2'b01, 1, 0, 0, 0, "R2 no dma yet");
      step(1, 1, 0, 3'b000, 0, 0, 2'b01, 1, 0, 0, 0, "R9 enq/deq in WAIT");
      step(0, 0, 1, 3'b000, 0, 0, 2'b10, 1, 1, 0, 0, "R3 eof starts dma");
      step(0, 0, 0, 3'b001, 0, 0, 2'b10, 1, 0, 0, 0, "R4 ch0 only");
      step(0, 0, 0, 3'b100, 0, 0, 2'b10, 1, 0, 0, 0, "R4 ch2 added");
      step(0, 0, 0, 3'b010, 0, 0, 2'b10, 1, 0, 1, 0, "R8 clean frame, dma busy");
      step(1, 1, 0, 3'b000, 0, 0, 2'b10, 1, 0, 0, 0, "R9 enq/deq in RUN");
      step(0, 0, 0, 3'b011, 1, 0, 2'b10, 1, 0, 0, 0, "R5 overrun flagged early");
      step(0, 0, 0, 3'b100, 0, 0, 2'b01, 0, 0, 0, 1, "R5 sticky overrun restart");
      step(0, 0, 0, 3'b000, 0, 0, 2'b01, 1, 0, 0, 0, "R5 camera back on");
      step(0, 0, 1, 3'b000, 0, 0, 2'b10, 1, 1, 0, 0, "R5 dma restarted");
      step(0, 0, 0, 3'b111, 0, 1, 2'b11, 1, 0, 1, 0, "R7 link missed");
      step(0, 1, 0, 3'b000, 0, 1, 2'b11, 1, 0, 0, 0, "R7 hold MISS");
      step(0, 0, 1, 3'b000, 0, 0, 2'b10, 1, 1, 0, 0, "R7 eof recovers");
      step(0, 0, 0, 3'b011, 0, 0, 2'b10, 1, 0, 0, 0, "R4 partial");
      step(1, 0, 0, 3'b100, 0, 0, 2'b10, 1, 0, 1, 0, "R9 enq merged with release");
      step(0, 0, 0, 3'b111, 0, 0, 2'b00, 0, 0, 1, 0, "R6 last buffer stops");
      step(0, 0, 0, 3'b000, 0, 0, 2'b00, 0, 0, 0, 0, "R6 stays stopped");
      @(negedge clk);
      enq_i = 0; deq_i = 0; eof_i = 0; ch_end_i = '0; overrun_i = 0; dma_idle_i = 0;
      repeat (3) @(negedge clk);
      done_drv = 1;
   end

   initial begin
      fork
         wait (done_drv);
         begin
            repeat (2000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule